// File: doc/BRIEF.md
# Page Write Load Controller

This block manages the write side of a byte-wide nonvolatile memory that is modelled in on-chip RAM. The host drives active-low chip-enable, write-enable and output-enable strobes. These strobes are not tied to the block clock. The block synchronises and de-glitches them, takes an address when a qualified write begins, and takes the data byte when the write ends. Loaded bytes collect in a page buffer. Each buffer slot is selected by the low six address bits.

A write that is accepted while the block is idle locks the page address, which is the address bits above the six offset bits. Later loads to the same page join the buffer. Loads to any other page are dropped. Each accepted load restarts a byte-load timeout. When the timeout runs out with no write in progress, the block raises busy and runs a programming timer of fixed length. It then sweeps the buffer into the array, one slot per cycle. Only slots that were actually loaded are written. A synchronous read port lets the surrounding logic see the array contents.

Top module: `page_load_ctrl`

## Requirements
- R1: A write is recognised only while chip-enable is low, write-enable is low and output-enable is high. Output-enable low or chip-enable high during a write-enable pulse leaves the array unchanged and busy low.
- R2: The address is taken when a qualified write begins, and the data byte when it ends. An address change during the pulse does not move the write, and the byte stored is the one present at the end of the pulse.
- R3: A page holds 64 bytes. Address bits [5:0] pick the byte in the page, and bits [ADDR_W-1:6] form the page address. Every byte loaded into a page reaches the array at its own address.
- R4: After the first accepted load, a load whose page address differs from the locked page is ignored. It does not change the array.
- R5: Each accepted load restarts a timeout of LOAD_CYC clock cycles. Programming (busy high) begins once the timeout expires with no write in progress, about LOAD_CYC cycles after the last accepted load began.
- R6: A page load has no overall time limit. Busy stays low through a load of all 64 bytes that lasts many times LOAD_CYC, as long as each gap is shorter than the timeout.
- R7: Busy stays high for at least PROG_CYC cycles, and then for the commit of one slot per cycle, at most PROG_CYC + 64 + 4 cycles in all. It then falls by itself.
- R8: A qualified write state lasting fewer than FILT_CYC clock cycles starts no write.
- R9: Write loads that begin while busy is high are ignored. They change no array byte and start no later programming cycle.
- R10: Bytes of the locked page that were not loaded keep their earlier array contents after the commit.
- R11: After reset, busy is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n_i | input | 1 | Chip-enable strobe, active low, asynchronous |
| we_n_i | input | 1 | Write-enable strobe, active low, asynchronous |
| oe_n_i | input | 1 | Output-enable strobe, active low, asynchronous |
| addr_i | input | ADDR_W | Write address, held stable through the strobe synchroniser delay |
| data_i | input | 8 | Write data, held stable through the synchroniser delay after the strobe ends |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | 8 | Array read data, one cycle after rd_addr_i |
| busy_o | output | 1 | High from the start of programming until the commit finishes |

## Verification
The hardest case to reach from the ports is a load that arrives while a page is already open, targets a different page, and falls between two valid loads. The stimulus first commits known bytes, including one at the foreign address and one unloaded slot in the target page. It then opens a page and interleaves a foreign-page pulse between two valid loads, with every gap well inside the timeout. Reading back after the commit shows the dropped byte, the kept bytes and the untouched slot.

// File: rtl/plc_pkg.sv
// Package: shared types for the page write load controller.
// Assumes: nothing beyond IEEE 1800-2017.
package plc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_PROG   = 2'd2,
        ST_COMMIT = 2'd3
    } plc_state_e;
endpackage

// File: rtl/plc_strobe_qual.sv
// Module: plc_strobe_qual
// Synchronises the three active-low strobes and qualifies the write state
// (chip-enable low, write-enable low, output-enable high) once it has held for
// FILT_CYC consecutive cycles. Emits one-cycle start and end pulses.
// Assumes: FILT_CYC >= 1; strobes may change at any time.
module plc_strobe_qual #(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n_i,
    input  logic we_n_i,
    input  logic oe_n_i,
    output logic wr_raw_o,
    output logic wr_act_o,
    output logic start_o,
    output logic end_o
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [2:0]    meta_q, sync_q;
    logic [CW-1:0] cnt_q;
    logic          act_q, act_d_q;

    // Two-stage synchroniser; idle value is all strobes inactive (high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 3'b111;
            sync_q <= 3'b111;
        end else begin
            meta_q <= {oe_n_i, we_n_i, ce_n_i};
            sync_q <= meta_q;
        end
    end

    assign wr_raw_o = !sync_q[0] && !sync_q[1] && sync_q[2];

    // Count consecutive write-state cycles and qualify after FILT_CYC of them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= 1'b0;
        end else if (!wr_raw_o) begin
            cnt_q <= '0;
            act_q <= 1'b0;
        end else begin
            if (cnt_q < CW'(FILT_CYC)) cnt_q <= cnt_q + 1'b1;
            if (cnt_q >= CW'(FILT_CYC - 1)) act_q <= 1'b1;
        end
    end

    // Delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) act_d_q <= 1'b0;
        else        act_d_q <= act_q;
    end

    assign wr_act_o = act_q;
    assign start_o  = act_q && !act_d_q;
    assign end_o    = !act_q && act_d_q;
endmodule

// File: rtl/plc_page_buffer.sv
// Module: plc_page_buffer
// Holds one page of loaded bytes with a valid flag per slot. One write port,
// one combinational read port for the commit sweep, and a clear of all flags.
// Assumes: write and clear never occur in the same cycle.
module plc_page_buffer #(
    parameter int OFF_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [OFF_W-1:0] wr_off_i,
    input  logic [7:0]       wr_data_i,
    input  logic [OFF_W-1:0] rd_off_i,
    output logic [7:0]       rd_data_o,
    output logic             rd_valid_o,
    input  logic             clear_i
);
    localparam int SLOTS = 1 << OFF_W;

    logic [7:0]       slot_q [SLOTS];
    logic [SLOTS-1:0] valid_q;

    // Slot data storage, no reset needed since valid flags gate use.
    always_ff @(posedge clk) begin
        if (wr_en_i) slot_q[wr_off_i] <= wr_data_i;
    end

    // Per-slot valid flags, one generate branch per slot.
    for (genvar g = 0; g < SLOTS; g++) begin : g_valid
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i)
                valid_q[g] <= 1'b0;
            else if (wr_en_i && (wr_off_i == OFF_W'(g)))
                valid_q[g] <= 1'b1;
        end
    end

    assign rd_data_o  = slot_q[rd_off_i];
    assign rd_valid_o = valid_q[rd_off_i];
endmodule

// File: rtl/plc_sequencer.sv
// Module: plc_sequencer
// Load/program/commit state machine. Locks the page on the first accepted
// load, filters later loads by page, runs the byte-load timeout and the
// programming timer, and sweeps the page buffer into the array.
// Assumes: start/end pulses come from plc_strobe_qual; LOAD_CYC, PROG_CYC >= 2.
module plc_sequencer
    import plc_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int OFF_W    = 6,
    parameter int LOAD_CYC = 5000,
    parameter int PROG_CYC = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              end_i,
    input  logic              wr_act_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        data_i,
    output logic              buf_we_o,
    output logic [OFF_W-1:0]  buf_off_o,
    output logic [7:0]        buf_data_o,
    output logic [OFF_W-1:0]  sweep_off_o,
    output logic              sweep_o,
    output logic              clear_o,
    output logic [ADDR_W-OFF_W-1:0] lock_pg_o,
    output logic              busy_o
);
    localparam int PG_W  = ADDR_W - OFF_W;
    localparam int LW    = $clog2(LOAD_CYC + 1);
    localparam int PW    = $clog2(PROG_CYC + 1);
    localparam int SLOTS = 1 << OFF_W;

    plc_state_e       state_q;
    logic [LW-1:0]    win_q;
    logic [PW-1:0]    prog_q;
    logic [OFF_W-1:0] idx_q;
    logic [OFF_W-1:0] off_q;
    logic [PG_W-1:0]  pg_q;
    logic             acc_q;
    logic             pg_hit;
    logic             expire;

    assign pg_hit = (addr_i[ADDR_W-1:OFF_W] == pg_q);
    assign expire = (state_q == ST_LOAD) && (win_q >= LW'(LOAD_CYC))
                    && !wr_act_i && !end_i;

    // Main state register and the timers it owns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            win_q   <= '0;
            prog_q  <= '0;
            idx_q   <= '0;
            off_q   <= '0;
            pg_q    <= '0;
            acc_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    acc_q <= 1'b0;
                    if (start_i) begin
                        acc_q   <= 1'b1;
                        pg_q    <= addr_i[ADDR_W-1:OFF_W];
                        off_q   <= addr_i[OFF_W-1:0];
                        win_q   <= '0;
                        state_q <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (win_q < LW'(LOAD_CYC)) win_q <= win_q + 1'b1;
                    if (start_i) begin
                        acc_q <= pg_hit;
                        if (pg_hit) begin
                            off_q <= addr_i[OFF_W-1:0];
                            win_q <= '0;
                        end
                    end else if (end_i) begin
                        acc_q <= 1'b0;
                    end
                    if (expire) begin
                        acc_q   <= 1'b0;
                        prog_q  <= '0;
                        state_q <= ST_PROG;
                    end
                end
                ST_PROG: begin
                    prog_q <= prog_q + 1'b1;
                    if (prog_q == PW'(PROG_CYC - 1)) begin
                        idx_q   <= '0;
                        state_q <= ST_COMMIT;
                    end
                end
                ST_COMMIT: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == OFF_W'(SLOTS - 1)) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign buf_we_o    = (state_q == ST_LOAD) && end_i && acc_q;
    assign buf_off_o   = off_q;
    assign buf_data_o  = data_i;
    assign sweep_o     = (state_q == ST_COMMIT);
    assign sweep_off_o = idx_q;
    assign clear_o     = (state_q == ST_COMMIT) && (idx_q == OFF_W'(SLOTS - 1));
    assign lock_pg_o   = pg_q;
    assign busy_o      = (state_q == ST_PROG) || (state_q == ST_COMMIT);
endmodule

// File: rtl/plc_array.sv
// Module: plc_array
// Storage array model: single write port, registered read port.
// Assumes: contents are undefined until written.
module plc_array #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [7:0]        rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];

    // Array write.
    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    // Registered read.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_o <= '0;
        else        rdata_o <= mem_q[raddr_i];
    end
endmodule

// File: rtl/page_load_ctrl.sv
// Module: page_load_ctrl (top)
// Byte-load and page-program controller for a RAM-modelled nonvolatile memory.
// Assumes: addr_i held from strobe fall until FILT_CYC+3 cycles later; data_i
// held until 4 cycles after the strobe ends.
module page_load_ctrl #(
    parameter int ADDR_W   = 11,
    parameter int FILT_CYC = 4,
    parameter int LOAD_CYC = 20000,
    parameter int PROG_CYC = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n_i,
    input  logic              we_n_i,
    input  logic              oe_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o,
    output logic              busy_o
);
    localparam int OFF_W = 6;
    localparam int PG_W  = ADDR_W - OFF_W;

    logic             wr_raw, wr_act, st_p, en_p;
    logic             buf_we, sweep, clr, slot_valid, arr_we;
    logic [OFF_W-1:0] buf_off, sweep_off;
    logic [7:0]       buf_wdata, slot_data;
    logic [PG_W-1:0]  lock_pg;

    plc_strobe_qual #(.FILT_CYC(FILT_CYC)) u_qual (
        .clk(clk), .rst_n(rst_n),
        .ce_n_i(ce_n_i), .we_n_i(we_n_i), .oe_n_i(oe_n_i),
        .wr_raw_o(wr_raw), .wr_act_o(wr_act), .start_o(st_p), .end_o(en_p)
    );

    plc_sequencer #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W),
        .LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_i(st_p), .end_i(en_p), .wr_act_i(wr_act),
        .addr_i(addr_i), .data_i(data_i),
        .buf_we_o(buf_we), .buf_off_o(buf_off), .buf_data_o(buf_wdata),
        .sweep_off_o(sweep_off), .sweep_o(sweep), .clear_o(clr),
        .lock_pg_o(lock_pg), .busy_o(busy_o)
    );

    plc_page_buffer #(.OFF_W(OFF_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(buf_we), .wr_off_i(buf_off), .wr_data_i(buf_wdata),
        .rd_off_i(sweep_off), .rd_data_o(slot_data), .rd_valid_o(slot_valid),
        .clear_i(clr)
    );

    assign arr_we = sweep && slot_valid;

    plc_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .we_i(arr_we), .waddr_i({lock_pg, sweep_off}), .wdata_i(slot_data),
        .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
    );
endmodule

// File: rtl/plc_checker.sv
// Module: plc_checker
// Temporal checks across the controller's sub-blocks, bound to the top.
module plc_checker #(
    parameter int PG_W     = 5,
    parameter int FILT_CYC = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            buf_we,
    input logic            arr_we,
    input logic            wr_raw,
    input logic            wr_act,
    input logic [PG_W-1:0] lock_pg
);
    AST_QUAL_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_act |-> $past(wr_raw)); // R1
    AST_FILTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((FILT_CYC >= 2) && $rose(wr_act)) |-> ($past(wr_raw) && $past(wr_raw, 2))); // R8
    AST_BUSY_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(wr_act)); // R5
    AST_ARRAY_WR_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy); // R7
    AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !buf_we); // R9
    AST_PAGE_LOCK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(lock_pg)); // R4
endmodule

bind page_load_ctrl plc_checker #(.PG_W(ADDR_W - 6), .FILT_CYC(FILT_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy_o), .buf_we(buf_we), .arr_we(arr_we),
    .wr_raw(wr_raw), .wr_act(wr_act), .lock_pg(lock_pg)
);

// File: tb/page_load_ctrl_test.sv
// Directed bench for page_load_ctrl: one task per scenario.
module page_load_ctrl_test;
    localparam int AW = 11;
    localparam int FC = 4;
    localparam int LC = 100;
    localparam int PC = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0, rd_addr = '0;
    logic [7:0] data = '0;
    logic [7:0] rd_data;
    logic busy;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    page_load_ctrl #(.ADDR_W(AW), .FILT_CYC(FC), .LOAD_CYC(LC), .PROG_CYC(PC)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n), .we_n_i(we_n), .oe_n_i(oe_n),
        .addr_i(addr), .data_i(data), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .busy_o(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One strobe pulse; ce/oe levels chosen by caller.
    task automatic pulse(input logic [AW-1:0] a, input logic [7:0] d,
                         input logic ce, input logic oe, input int low);
        addr = a; data = d; ce_n = ce; oe_n = oe;
        cyc(1);
        we_n = 1'b0;
        cyc(low);
        we_n = 1'b1;
        cyc(8);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        pulse(a, d, 1'b0, 1'b1, 10);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        rd_addr = a;
        cyc(2);
        d = rd_data;
    endtask

    // Wait for a full program/commit cycle to finish.
    task automatic wait_done();
        int t = 0;
        while (!busy && t < LC + 100) begin cyc(1); t++; end
        t = 0;
        while (busy && t < PC + 200) begin cyc(1); t++; end
        cyc(2);
    endtask

    // Observe busy for n cycles; return 1 if it ever rose.
    task automatic watch_busy(input int n, output bit seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            cyc(1);
            if (busy) seen = 1;
        end
    endtask

    task automatic t_reset();
        check("R11 busy after reset", busy, 0);
    endtask

    task automatic t_single();
        logic [7:0] v;
        int t = 0;
        wr(11'h045, 8'h3C);
        while (!busy && t < LC + 100) begin cyc(1); t++; end
        // WE rose 8 cycles before t began; start pulse ~3 cycles before that rise
        n_chk++;
        if (t + 8 < LC - 15 || t + 8 > LC + 15) begin
            n_bad++;
            $display("FAIL R5 busy delay actual=%0d expected=~%0d", t + 8, LC);
        end
        t = 0;
        while (busy && t < PC + 200) begin cyc(1); t++; end
        n_chk++;
        if (t < PC || t > PC + 64 + 4) begin
            n_bad++;
            $display("FAIL R7 busy width actual=%0d expected=%0d..%0d", t, PC, PC + 68);
        end
        cyc(2);
        rd(11'h045, v);
        check("R3 single byte", v, 8'h3C);
    endtask

    task automatic t_blocked();
        logic [7:0] v;
        bit seen;
        pulse(11'h045, 8'hF1, 1'b0, 1'b0, 10);   // output-enable low
        watch_busy(LC + 60, seen);
        check("R1 oe low busy", seen, 0);
        pulse(11'h045, 8'hF2, 1'b1, 1'b1, 10);   // chip-enable high
        watch_busy(LC + 60, seen);
        check("R1 ce high busy", seen, 0);
        rd(11'h045, v);
        check("R1 blocked data", v, 8'h3C);
    endtask

    task automatic t_glitch();
        logic [7:0] v;
        bit seen;
        pulse(11'h045, 8'hE7, 1'b0, 1'b1, FC - 2);
        watch_busy(LC + 60, seen);
        check("R8 short pulse busy", seen, 0);
        rd(11'h045, v);
        check("R8 short pulse data", v, 8'h3C);
    endtask

    task automatic t_capture();
        logic [7:0] v;
        wr(11'h13F, 8'h77);
        wait_done();
        addr = 11'h100; data = 8'h00; ce_n = 1'b0; oe_n = 1'b1;
        cyc(1);
        we_n = 1'b0;
        cyc(12);
        addr = 11'h13F; data = 8'h5A;
        cyc(3);
        we_n = 1'b1;
        cyc(8);
        ce_n = 1'b1;
        wait_done();
        rd(11'h100, v);
        check("R2 captured addr/data", v, 8'h5A);
        rd(11'h13F, v);
        check("R2 late address untouched", v, 8'h77);
    endtask

    task automatic t_page();
        logic [7:0] v;
        bit early = 0;
        int bad = 0;
        for (int i = 0; i < 64; i++) begin
            wr(AW'(11'h200 + i), 8'(i) ^ 8'hA5);
            if (busy) early = 1;
        end
        check("R6 no busy during long page load", early, 0);
        wait_done();
        for (int i = 0; i < 64; i++) begin
            rd(AW'(11'h200 + i), v);
            if (v != (8'(i) ^ 8'hA5)) bad++;
        end
        check("R3 full page mismatches", bad, 0);
    endtask

    task automatic t_mismatch();
        logic [7:0] v;
        wr(11'h2C7, 8'h99);
        wait_done();
        wr(11'h341, 8'h44);
        wait_done();
        wr(11'h2C1, 8'h21);
        cyc(10);
        wr(11'h341, 8'h66);
        cyc(10);
        wr(11'h2C2, 8'h22);
        wait_done();
        rd(11'h2C1, v); check("R3 first of page", v, 8'h21);
        rd(11'h2C2, v); check("R4 load after foreign", v, 8'h22);
        rd(11'h341, v); check("R4 foreign page dropped", v, 8'h44);
        rd(11'h2C7, v); check("R10 unloaded slot kept", v, 8'h99);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] v;
        bit seen;
        int t = 0;
        wr(11'h0A0, 8'h12);
        while (!busy && t < LC + 100) begin cyc(1); t++; end
        check("R9 busy reached", busy, 1);
        wr(11'h0A0, 8'hEE);
        wr(11'h0A1, 8'hEF);
        t = 0;
        while (busy && t < PC + 200) begin cyc(1); t++; end
        watch_busy(LC + 60, seen);
        check("R9 no late programming", seen, 0);
        rd(11'h0A0, v);
        check("R9 byte during busy", v, 8'h12);
    endtask

    initial begin : watchdog
        cyc(150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_single();
        t_blocked();
        t_glitch();
        t_capture();
        t_page();
        t_mismatch();
        t_busy_ignore();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule